// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block connects two 8-bit buses, called A and B, and can pass data in either direction or in both at once. Each direction has a storage register with its own capture clock. A select input picks what that direction drives: the live value of the opposite bus, or the value held in the register. The A-to-B driver has an active-high enable and the B-to-A driver has an active-low enable. Each bus is modelled as three parts: an input from the outside, a flag saying whether an outside agent drives it, and a driven output with its own enable. This keeps the whole block synthesizable.

The block runs on a single system clock. The capture clocks are sampled on that clock, and a register loads on each sampled low-to-high change. Outputs and their enables are registered, so a change of select or enable appears exactly once, on the system clock edge that follows it. A per-bus keeper stands in for bus-hold. When nothing drives a bus, its resolved value stays at the level it last had. With both directions live and enabled, each bus is driven from the other, and the pair holds its value.

Top module: `regxcvr8`

## Requirements
- R1: While `rst_n` is low on a `clk` edge, both storage registers, both bus keepers, both data outputs and both output enables are cleared to zero.
- R2: `b_oe` equals `en_ab` as sampled at the previous `clk` edge (active high). `a_oe` equals the inverse of `en_ba_n` as sampled at the previous edge (active low).
- R3: The resolved value of a bus is its external input when its external-drive flag is 1. Otherwise it is the block's own output on that bus when that output's enable is 1. Otherwise it is the keeper value. With `sel_ab`=0 and `en_ab`=1, `b_out` takes the resolved A value on the next `clk` edge. With `sel_ba`=0 and `en_ba_n`=0, `a_out` takes the resolved B value in the same way.
- R4: With `sel_ab`=1 and `en_ab`=1, `b_out` takes the A-to-B register value on the next `clk` edge. With `sel_ba`=1 and `en_ba_n`=0, `a_out` takes the B-to-A register value.
- R5: On a `clk` edge where `clk_ab` is 1 and it was 0 at the previous edge, the A-to-B register loads the resolved A value. `clk_ba` loads the B-to-A register from B in the same way. Loading happens whatever the select and enable inputs are.
- R6: A register does not change on an edge where its capture clock is 0, or where it is held at 1 after its rising edge.
- R7: While a direction's enable is inactive, its data output keeps its previous value.
- R8: Data outputs change only at `clk` edges. A select change applied between edges does not show on the output before the next edge, and then it shows as a single step to the new source.
- R9: A bus that neither an outside agent nor the block drives keeps its last resolved value. That kept value is what is forwarded and captured.
- R10: With both selects at 0, both directions enabled, no external driver, and both outputs equal, `a_out` and `b_out` keep that value on every later edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| clk_ab | input | 1 | Capture clock of the A-to-B register |
| clk_ba | input | 1 | Capture clock of the B-to-A register |
| sel_ab | input | 1 | A-to-B source: 0 live, 1 stored |
| sel_ba | input | 1 | B-to-A source: 0 live, 1 stored |
| en_ab | input | 1 | A-to-B driver enable, active high |
| en_ba_n | input | 1 | B-to-A driver enable, active low |
| a_in | input | W | Value placed on bus A by an outside agent |
| a_ext | input | 1 | Outside agent drives bus A |
| b_in | input | W | Value placed on bus B by an outside agent |
| b_ext | input | 1 | Outside agent drives bus B |
| a_out | output | W | Block's drive onto bus A |
| a_oe | output | 1 | Block drives bus A |
| b_out | output | W | Block's drive onto bus B |
| b_oe | output | 1 | Block drives bus B |

## Verification
The assertions assume that an outside agent never drives a bus while the block's enable for that bus is set at a sample point. They also assume that the loop-hold property starts only from equal outputs, because unequal values in that loop would swap on every edge. The stimulus keeps to this by tying each external-drive flag to the inactive state of the matching enable. The loop is entered only after one direction has already copied the other bus. A bus-resolution model in the bench counts any sample where both sides drive different values, and it expects that count to stay zero.

// File: rtl/regxcvr8.sv
module regxcvr8 #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clk_ab,
  input  logic         clk_ba,
  input  logic         sel_ab,
  input  logic         sel_ba,
  input  logic         en_ab,
  input  logic         en_ba_n,
  input  logic [W-1:0] a_in,
  input  logic         a_ext,
  input  logic [W-1:0] b_in,
  input  logic         b_ext,
  output logic [W-1:0] a_out,
  output logic         a_oe,
  output logic [W-1:0] b_out,
  output logic         b_oe
);

  logic [W-1:0] ab_q, ba_q, a_keep, b_keep, a_bus, b_bus;
  logic         clk_ab_d, clk_ba_d;

  assign a_bus = a_ext ? a_in : (a_oe ? a_out : a_keep);
  assign b_bus = b_ext ? b_in : (b_oe ? b_out : b_keep);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ab_q     <= '0;
      ba_q     <= '0;
      a_keep   <= '0;
      b_keep   <= '0;
      a_out    <= '0;
      b_out    <= '0;
      a_oe     <= 1'b0;
      b_oe     <= 1'b0;
      clk_ab_d <= 1'b0;
      clk_ba_d <= 1'b0;
    end else begin
      clk_ab_d <= clk_ab;
      clk_ba_d <= clk_ba;
      if (clk_ab && !clk_ab_d) ab_q <= a_bus;
      if (clk_ba && !clk_ba_d) ba_q <= b_bus;
      a_keep <= a_bus;
      b_keep <= b_bus;
      b_oe   <= en_ab;
      a_oe   <= !en_ba_n;
      if (en_ab)    b_out <= sel_ab ? ab_q : a_bus;
      if (!en_ba_n) a_out <= sel_ba ? ba_q : b_bus;
    end
  end

endmodule

module regxcvr8_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         clk_ab,
  input logic         clk_ba,
  input logic         sel_ab,
  input logic         sel_ba,
  input logic         en_ab,
  input logic         en_ba_n,
  input logic         a_ext,
  input logic         b_ext,
  input logic [W-1:0] a_bus,
  input logic [W-1:0] b_bus,
  input logic [W-1:0] ab_q,
  input logic [W-1:0] ba_q,
  input logic [W-1:0] a_out,
  input logic [W-1:0] b_out,
  input logic         a_oe,
  input logic         b_oe
);

  p_oe_ab_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (b_oe == $past(en_ab)));
  p_oe_ba_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (a_oe == !$past(en_ba_n)));

  p_live_ab_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (en_ab && !sel_ab) |=> (b_out == $past(a_bus)));
  p_live_ba_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_ba_n && !sel_ba) |=> (a_out == $past(b_bus)));

  p_stored_ab_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (en_ab && sel_ab) |=> (b_out == $past(ab_q)));
  p_stored_ba_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_ba_n && sel_ba) |=> (a_out == $past(ba_q)));

  p_nocap_ab_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_ab |=> $stable(ab_q));
  p_nocap_ba_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_ba |=> $stable(ba_q));

  p_hold_ab_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !en_ab |=> $stable(b_out));
  p_hold_ba_r7: assert property (@(posedge clk) disable iff (!rst_n)
    en_ba_n |=> $stable(a_out));

  p_keep_a_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !a_ext && !a_oe) |-> (a_bus == $past(a_bus)));
  p_keep_b_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !b_ext && !b_oe) |-> (b_bus == $past(b_bus)));

  p_loop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_ab && !sel_ba && en_ab && !en_ba_n && a_oe && b_oe &&
     !a_ext && !b_ext && (a_out == b_out))
    |=> ((a_out == $past(a_out)) && (b_out == $past(b_out))));

endmodule

bind regxcvr8 regxcvr8_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .clk_ab(clk_ab), .clk_ba(clk_ba),
  .sel_ab(sel_ab), .sel_ba(sel_ba), .en_ab(en_ab), .en_ba_n(en_ba_n),
  .a_ext(a_ext), .b_ext(b_ext), .a_bus(a_bus), .b_bus(b_bus),
  .ab_q(ab_q), .ba_q(ba_q), .a_out(a_out), .b_out(b_out),
  .a_oe(a_oe), .b_oe(b_oe)
);

// File: tb/test_regxcvr8.sv
module test_regxcvr8;
  localparam int W = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic clk_ab = 0, clk_ba = 0, sel_ab = 0, sel_ba = 0, en_ab = 0, en_ba_n = 1;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic a_ext = 0, b_ext = 0;
  logic [W-1:0] a_out, b_out;
  logic a_oe, b_oe;

  int checks = 0, fails = 0, contention = 0;
  bit done = 0;

  logic [W-1:0] m_ab, m_ba, m_akeep, m_bkeep, m_aout, m_bout;
  logic m_aoe, m_boe, m_cab, m_cba;

  regxcvr8 #(.W(W)) i_regxcvr8 (
    .clk(clk), .rst_n(rst_n), .clk_ab(clk_ab), .clk_ba(clk_ba),
    .sel_ab(sel_ab), .sel_ba(sel_ba), .en_ab(en_ab), .en_ba_n(en_ba_n),
    .a_in(a_in), .a_ext(a_ext), .b_in(b_in), .b_ext(b_ext),
    .a_out(a_out), .a_oe(a_oe), .b_out(b_out), .b_oe(b_oe)
  );

  always #4 clk = ~clk;

  task automatic chk(input string tag, input string what, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic chk_all(input string tag);
    chk(tag, "a_out", a_out, m_aout);
    chk(tag, "b_out", b_out, m_bout);
    chk(tag, "a_oe", W'(a_oe), W'(m_aoe));
    chk(tag, "b_oe", W'(b_oe), W'(m_boe));
    if ((a_ext && a_oe && a_in != a_out) || (b_ext && b_oe && b_in != b_out)) contention++;
  endtask

  task automatic model_reset();
    m_ab = '0; m_ba = '0; m_akeep = '0; m_bkeep = '0; m_aout = '0; m_bout = '0;
    m_aoe = 0; m_boe = 0; m_cab = 0; m_cba = 0;
  endtask

  // Called right after inputs change at a falling edge.
  task automatic tick(input string tag);
    logic [W-1:0] ba, bb, n_ab, n_ba;
    #1;
    chk({tag, " R8 mid-cycle"}, "a_out", a_out, m_aout);
    chk({tag, " R8 mid-cycle"}, "b_out", b_out, m_bout);
    ba = a_ext ? a_in : (m_aoe ? m_aout : m_akeep);
    bb = b_ext ? b_in : (m_boe ? m_bout : m_bkeep);
    n_ab = (clk_ab && !m_cab) ? ba : m_ab;
    n_ba = (clk_ba && !m_cba) ? bb : m_ba;
    if (en_ab)    m_bout = sel_ab ? m_ab : ba;
    if (!en_ba_n) m_aout = sel_ba ? m_ba : bb;
    m_ab = n_ab; m_ba = n_ba; m_akeep = ba; m_bkeep = bb;
    m_cab = clk_ab; m_cba = clk_ba; m_boe = en_ab; m_aoe = !en_ba_n;
    @(posedge clk); #1;
    chk_all(tag);
  endtask

  task automatic probe_stored(input string tag);
    @(negedge clk); clk_ab = 0; clk_ba = 0; sel_ab = 1; sel_ba = 1;
    en_ab = 1; en_ba_n = 0; a_ext = 0; b_ext = 0; tick(tag);
    @(negedge clk); tick(tag);
  endtask

  initial begin
    model_reset();
    @(negedge clk); @(negedge clk);
    @(posedge clk); #1;
    chk_all("R1 reset");
    @(negedge clk); rst_n = 1;

    // R2..R7: sweep every select/enable combination over several data patterns
    for (int c = 0; c < 16; c++) begin
      for (int p = 0; p < 4; p++) begin
        @(negedge clk);
        sel_ab = c[0]; sel_ba = c[1]; en_ab = c[2]; en_ba_n = c[3];
        a_in = W'(8'h3C + 8'd37 * c + 8'd91 * p);
        b_in = W'(8'hA5 ^ (8'd53 * c + 8'd17 * p));
        a_ext = en_ba_n && (p != 3);
        b_ext = !en_ab && (p != 2);
        clk_ab = 0; clk_ba = 0;
        tick("R2 R3 R4 R7 R9 sweep");
        @(negedge clk); clk_ab = p[0]; clk_ba = 1;
        tick("R5 capture sweep");
        @(negedge clk); a_in = ~a_in; b_in = ~b_in;
        tick("R6 R7 hold sweep");
      end
    end

    // R6: capture clock held high does not reload
    @(negedge clk); en_ab = 0; en_ba_n = 1; a_ext = 1; b_ext = 1;
    a_in = 8'h11; b_in = 8'h22; clk_ab = 0; clk_ba = 0; tick("R6 setup");
    @(negedge clk); clk_ab = 1; clk_ba = 1; tick("R5 load");
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); a_in = 8'h40 + 8'(i); b_in = 8'h80 + 8'(i); tick("R6 held high");
    end
    probe_stored("R6 stored probe");
    chk("R6", "b_out stored", b_out, 8'h11);
    chk("R6", "a_out stored", a_out, 8'h22);

    // R8: select flips between edges, output steps once per edge
    @(negedge clk); en_ba_n = 1; a_ext = 1; a_in = 8'hE7; sel_ab = 0; tick("R8 live");
    chk("R8", "b_out live", b_out, 8'hE7);
    @(negedge clk); sel_ab = 1; tick("R8 to stored");
    chk("R8", "b_out stored", b_out, 8'h11);
    @(negedge clk); sel_ab = 0; tick("R8 to live");
    chk("R8", "b_out live again", b_out, 8'hE7);

    // R9: undriven bus keeps last value and that value is captured
    @(negedge clk); en_ab = 0; a_ext = 1; a_in = 8'h6D; tick("R9 drive");
    @(negedge clk); a_ext = 0; a_in = 8'h00; clk_ab = 0; tick("R9 release");
    @(negedge clk); clk_ab = 1; tick("R9 capture kept");
    @(negedge clk); en_ab = 1; sel_ab = 0; tick("R9 forward kept");
    chk("R9", "b_out from keeper", b_out, 8'h6D);
    @(negedge clk); sel_ab = 1; tick("R9 stored kept");
    chk("R9", "b_out stored keeper", b_out, 8'h6D);

    // R10: both live and enabled with no external driver holds the value
    @(negedge clk); sel_ab = 0; sel_ba = 0; en_ab = 1; en_ba_n = 1;
    a_ext = 1; a_in = 8'h5A; b_ext = 0; tick("R10 setup");
    @(negedge clk); tick("R10 setup");
    @(negedge clk); a_ext = 0; a_in = 8'hFF; en_ba_n = 0; tick("R10 enter");
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); tick("R10 hold");
    end
    chk("R10", "a_out", a_out, 8'h5A);
    chk("R10", "b_out", b_out, 8'h5A);

    // R1: reset mid-run clears stored state
    @(negedge clk); rst_n = 0; @(posedge clk); #1;
    model_reset();
    chk_all("R1 second reset");
    @(negedge clk); rst_n = 1; en_ab = 0; en_ba_n = 1; a_ext = 0; b_ext = 0; tick("R1 idle");
    probe_stored("R1 stored probe");
    chk("R1", "b_out stored after reset", b_out, 8'h00);
    chk("R1", "a_out stored after reset", a_out, 8'h00);

    checks++;
    if (contention != 0) begin
      fails++;
      $display("FAIL R3 bus contention actual=%0d expected=0", contention);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule